// File: doc/BRIEF.md
# Partially Connected Fixed-Priority Crossbar Switch

This block links three bus masters to three targets. The masters are a DMA engine, a host port and the CPU. The targets are on-chip memory, a peripheral bus and an external memory interface. Each master presents a request with an address, a write flag and write data, and holds the request until it sees ready. Masters that address different targets are served in the same cycle. When several masters want the same target, a fixed priority order picks the winner: DMA first, then host, then CPU. No rotation or fairness scheme is applied.

A grant is kept until the target signals completion, so a transfer in progress is never preempted. Some paths are not wired. The host cannot reach the peripheral target. A request on a missing path, or to an address outside every target window, completes in its own cycle with an error flag and never reaches a target. Each target port carries the ID of the granted master, so responses can be routed back to the master that made the request.

Top module: `xbar_fp_switch`

## Requirements
- R1: Masters that decode to different targets are all forwarded in the same cycle, and each target's `t_req_o` bit is high in that cycle.
- R2: When several masters want an idle target, the lowest master ID wins. The IDs are DMA=0, host=1 and CPU=2.
- R3: Once a target is forwarding a request, it keeps the same `t_mid_o` on every following cycle until a cycle in which `t_done_i` is high.
- R4: A host (ID 1) request that decodes to the peripheral target (index 1) gives `m_rdy_o` and `m_err_o` high in that same cycle. `t_req_o[1]` never carries master ID 1.
- R5: An address outside every window gives `m_rdy_o` and `m_err_o` in the same cycle and is not forwarded. The windows are: memory (target 0) at 0x0000_0000–0x0003_FFFF, peripheral (target 1) at 0x4000_0000–0x4000_FFFF, and external (target 2) at 0x8000_0000–0x8FFF_FFFF.
- R6: A master that has not been granted keeps `m_rdy_o` low. `m_rdy_o` is never high without `m_req_i`.
- R7: On a target port, `t_mid_o`, `t_addr_o`, `t_we_o` and `t_wdata_o` are those of the granted master.
- R8: A granted master sees `m_rdy_o` high, with `m_err_o` low, in the cycle its target raises `t_done_i`. In that cycle `m_rdata_o` equals that target's `t_rdata_i`.
- R9: During reset, and after it with no requests, all `t_req_o`, `m_rdy_o` and `m_err_o` bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| m_req_i | input | 3 | Request per master |
| m_addr_i | input | 3x32 | Address per master |
| m_we_i | input | 3 | Write flag per master |
| m_wdata_i | input | 3x32 | Write data per master |
| m_rdy_o | output | 3 | Transfer complete per master |
| m_err_o | output | 3 | Error with completion per master |
| m_rdata_o | output | 3x32 | Read data per master |
| t_req_o | output | 3 | Request per target |
| t_addr_o | output | 3x32 | Address per target |
| t_we_o | output | 3 | Write flag per target |
| t_wdata_o | output | 3x32 | Write data per target |
| t_mid_o | output | 3x2 | Granted master ID per target |
| t_done_i | input | 3 | Target completes the current transfer |
| t_rdata_i | input | 3x32 | Read data per target |

## Verification
The hardest case to reach from the ports is a higher-priority master arriving while a lower-priority master already holds a target. The bench reaches it by asserting a CPU request with completion held low, so the grant locks at the next edge. DMA then requests the same target and is kept waiting for several cycles. The bench checks that the CPU keeps the port and that DMA sees no ready until the CPU transfer completes. A table of single-cycle patterns covers the parallel, contention and rejected-path cases, and boundary addresses at the edge of the memory window cover decoding.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NM   = 3;
  localparam int NT   = 3;
  localparam int MIDW = $clog2(NM);

  localparam int MID_DMA  = 0;
  localparam int MID_HOST = 1;
  localparam int MID_CPU  = 2;

  localparam int TGT_MEM = 0;
  localparam int TGT_PER = 1;
  localparam int TGT_EXT = 2;

  // connectivity matrix: host has no route to the peripheral bus
  function automatic logic path_ok(input int mid, input int tgt);
    return !(mid == MID_HOST && tgt == TGT_PER);
  endfunction
endpackage

// File: rtl/xbar_addr_dec.sv
module xbar_addr_dec
  import xbar_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          MID     = 0,
  parameter logic [31:0] MEM_BASE = 32'h0000_0000,
  parameter int          MEM_LG2  = 18,
  parameter logic [31:0] PER_BASE = 32'h4000_0000,
  parameter int          PER_LG2  = 16,
  parameter logic [31:0] EXT_BASE = 32'h8000_0000,
  parameter int          EXT_LG2  = 28
) (
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  output logic [NT-1:0] sel_o,
  output logic          err_o
);
  localparam logic [AW-1:0] BASE [NT] = '{AW'(MEM_BASE), AW'(PER_BASE), AW'(EXT_BASE)};
  localparam int            LG2  [NT] = '{MEM_LG2, PER_LG2, EXT_LG2};

  logic [NT-1:0] hit;

  for (genvar t = 0; t < NT; t++) begin : g_win
    assign hit[t]   = (addr_i >> LG2[t]) == (BASE[t] >> LG2[t]);
    assign sel_o[t] = req_i && hit[t] && path_ok(MID, t);
  end

  assign err_o = req_i && (sel_o == '0);
endmodule

// File: rtl/xbar_tgt_arb.sv
module xbar_tgt_arb #(
  parameter int NM  = 3,
  parameter int IDW = $clog2(NM)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NM-1:0]  want_i,
  input  logic           done_i,
  output logic [NM-1:0]  gnt_o,
  output logic           vld_o,
  output logic [IDW-1:0] id_o
);
  logic           own_vld_q;
  logic [IDW-1:0] own_q;
  logic [IDW-1:0] pick;

  // fixed priority: lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NM - 1; i >= 0; i--) begin
      if (want_i[i]) pick = IDW'(i);
    end
  end

  assign id_o  = own_vld_q ? own_q : pick;
  assign vld_o = own_vld_q || (|want_i);
  assign gnt_o = vld_o ? (NM'(1) << id_o) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= 1'b0;
      own_q     <= '0;
    end else if (vld_o && !done_i) begin
      own_vld_q <= 1'b1;
      own_q     <= id_o;
    end else if (done_i) begin
      own_vld_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xbar_resp_mux.sv
module xbar_resp_mux #(
  parameter int NT = 3,
  parameter int DW = 32
) (
  input  logic [NT-1:0]         gnt_i,
  input  logic [NT-1:0]         done_i,
  input  logic [NT-1:0][DW-1:0] rdata_i,
  input  logic                  err_i,
  output logic                  rdy_o,
  output logic                  err_o,
  output logic [DW-1:0]         rdata_o
);
  always_comb begin
    rdy_o   = err_i;
    rdata_o = '0;
    for (int t = 0; t < NT; t++) begin
      if (gnt_i[t]) begin
        rdata_o = rdata_i[t];
        if (done_i[t]) rdy_o = 1'b1;
      end
    end
  end

  assign err_o = err_i;
endmodule

// File: rtl/xbar_fp_switch.sv
module xbar_fp_switch
  import xbar_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter logic [31:0] MEM_BASE = 32'h0000_0000,
  parameter int          MEM_LG2  = 18,
  parameter logic [31:0] PER_BASE = 32'h4000_0000,
  parameter int          PER_LG2  = 16,
  parameter logic [31:0] EXT_BASE = 32'h8000_0000,
  parameter int          EXT_LG2  = 28
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NM-1:0]             m_req_i,
  input  logic [NM-1:0][AW-1:0]     m_addr_i,
  input  logic [NM-1:0]             m_we_i,
  input  logic [NM-1:0][DW-1:0]     m_wdata_i,
  output logic [NM-1:0]             m_rdy_o,
  output logic [NM-1:0]             m_err_o,
  output logic [NM-1:0][DW-1:0]     m_rdata_o,
  output logic [NT-1:0]             t_req_o,
  output logic [NT-1:0][AW-1:0]     t_addr_o,
  output logic [NT-1:0]             t_we_o,
  output logic [NT-1:0][DW-1:0]     t_wdata_o,
  output logic [NT-1:0][MIDW-1:0]   t_mid_o,
  input  logic [NT-1:0]             t_done_i,
  input  logic [NT-1:0][DW-1:0]     t_rdata_i
);
  logic [NM-1:0][NT-1:0] sel;
  logic [NM-1:0]         dec_err;
  logic [NT-1:0][NM-1:0] want;
  logic [NT-1:0][NM-1:0] gnt;
  logic [NM-1:0][NT-1:0] gnt_m;

  for (genvar m = 0; m < NM; m++) begin : g_dec
    xbar_addr_dec #(
      .AW(AW), .MID(m),
      .MEM_BASE(MEM_BASE), .MEM_LG2(MEM_LG2),
      .PER_BASE(PER_BASE), .PER_LG2(PER_LG2),
      .EXT_BASE(EXT_BASE), .EXT_LG2(EXT_LG2)
    ) u_dec (
      .req_i (m_req_i[m]),
      .addr_i(m_addr_i[m]),
      .sel_o (sel[m]),
      .err_o (dec_err[m])
    );
  end

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    for (genvar m = 0; m < NM; m++) begin : g_tr
      assign want[t][m]  = sel[m][t];
      assign gnt_m[m][t] = gnt[t][m];
    end

    xbar_tgt_arb #(.NM(NM), .IDW(MIDW)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .want_i(want[t]),
      .done_i(t_done_i[t]),
      .gnt_o (gnt[t]),
      .vld_o (t_req_o[t]),
      .id_o  (t_mid_o[t])
    );

    always_comb begin
      t_addr_o[t]  = '0;
      t_we_o[t]    = 1'b0;
      t_wdata_o[t] = '0;
      for (int m = 0; m < NM; m++) begin
        if (gnt[t][m]) begin
          t_addr_o[t]  = m_addr_i[m];
          t_we_o[t]    = m_we_i[m];
          t_wdata_o[t] = m_wdata_i[m];
        end
      end
    end
  end

  for (genvar m = 0; m < NM; m++) begin : g_rsp
    xbar_resp_mux #(.NT(NT), .DW(DW)) u_rsp (
      .gnt_i  (gnt_m[m]),
      .done_i (t_done_i),
      .rdata_i(t_rdata_i),
      .err_i  (dec_err[m]),
      .rdy_o  (m_rdy_o[m]),
      .err_o  (m_err_o[m]),
      .rdata_o(m_rdata_o[m])
    );
  end
endmodule

// File: rtl/xbar_fp_switch_chk.sv
module xbar_fp_switch_chk
  import xbar_pkg::*;
(
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NM-1:0]           m_req_i,
  input logic [NM-1:0]           m_rdy_o,
  input logic [NM-1:0]           m_err_o,
  input logic [NT-1:0]           t_req_o,
  input logic [NT-1:0][MIDW-1:0] t_mid_o,
  input logic [NT-1:0]           t_done_i
);
  for (genvar t = 0; t < NT; t++) begin : g_t
    AST_GRANT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (t_req_o[t] && !t_done_i[t]) |=> (t_req_o[t] && t_mid_o[t] == $past(t_mid_o[t]))); // R3
    AST_MID_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      t_req_o[t] |-> (int'(t_mid_o[t]) < NM)); // R7
  end

  AST_HOST_NO_PER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(t_req_o[TGT_PER] && t_mid_o[TGT_PER] == MIDW'(MID_HOST))); // R4

  for (genvar m = 0; m < NM; m++) begin : g_m
    AST_ERR_WITH_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_err_o[m] |-> m_rdy_o[m]); // R5
    AST_RDY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      m_rdy_o[m] |-> m_req_i[m]); // R6
  end
endmodule

bind xbar_fp_switch xbar_fp_switch_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .m_req_i (m_req_i),
  .m_rdy_o (m_rdy_o),
  .m_err_o (m_err_o),
  .t_req_o (t_req_o),
  .t_mid_o (t_mid_o),
  .t_done_i(t_done_i)
);

// File: tb/xbar_fp_switch_tb.sv
module xbar_fp_switch_tb;
  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic [2:0]          m_req_i = '0;
  logic [2:0][31:0]    m_addr_i = '0;
  logic [2:0]          m_we_i = '0;
  logic [2:0][31:0]    m_wdata_i = '0;
  logic [2:0]          m_rdy_o, m_err_o;
  logic [2:0][31:0]    m_rdata_o;
  logic [2:0]          t_req_o, t_we_o;
  logic [2:0][31:0]    t_addr_o, t_wdata_o;
  logic [2:0][1:0]     t_mid_o;
  logic [2:0]          t_done_i = '0;
  logic [2:0][31:0]    t_rdata_i = '0;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  xbar_fp_switch u_dut (.*);

  // req, per-master target code (0 mem,1 per,2 ext,3 unmapped), expected t_req, t_mid, rdy, err
  typedef struct packed {
    logic [2:0] req;
    logic [5:0] sel;
    logic [2:0] e_treq;
    logic [5:0] e_tmid;
    logic [2:0] e_rdy;
    logic [2:0] e_err;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    {3'b001, 6'b000000, 3'b001, 6'b000000, 3'b001, 3'b000},
    {3'b111, 6'b000000, 3'b001, 6'b000000, 3'b001, 3'b000},
    {3'b110, 6'b101000, 3'b100, 6'b010000, 3'b010, 3'b000},
    {3'b111, 6'b100001, 3'b111, 6'b100001, 3'b111, 3'b000},
    {3'b010, 6'b000100, 3'b000, 6'b000000, 3'b010, 3'b010},
    {3'b100, 6'b110000, 3'b000, 6'b000000, 3'b100, 3'b100},
    {3'b110, 6'b010100, 3'b010, 6'b001000, 3'b110, 3'b010},
    {3'b101, 6'b010001, 3'b010, 6'b000000, 3'b001, 3'b000},
    {3'b000, 6'b000000, 3'b000, 6'b000000, 3'b000, 3'b000},
    {3'b111, 6'b000010, 3'b101, 6'b000001, 3'b011, 3'b000}
  };

  function automatic logic [31:0] addr_of(input logic [1:0] code, input int m);
    case (code)
      2'd0:    return 32'h0000_0100 + 32'(m * 4);
      2'd1:    return 32'h4000_0010;
      2'd2:    return 32'h8000_0200;
      default: return 32'h2000_0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R9 treq in reset", 64'(t_req_o), 64'h0);
    chk("R9 rdy in reset", 64'({m_rdy_o, m_err_o}), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk_i); #2;
    chk("R9 treq after reset", 64'(t_req_o), 64'h0);
    chk("R9 rdy after reset", 64'({m_rdy_o, m_err_o}), 64'h0);

    // table: R1 R2 R4 R5 R8, targets finish in the same cycle
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      m_req_i  = VEC[v].req;
      t_done_i = 3'b111;
      for (int m = 0; m < 3; m++) m_addr_i[m] = addr_of(VEC[v].sel[2*m +: 2], m);
      #2;
      chk($sformatf("R1 R4 R5 treq v%0d", v), 64'(t_req_o), 64'(VEC[v].e_treq));
      for (int t = 0; t < 3; t++)
        if (VEC[v].e_treq[t])
          chk($sformatf("R2 mid v%0d t%0d", v, t), 64'(t_mid_o[t]), 64'(VEC[v].e_tmid[2*t +: 2]));
      chk($sformatf("R8 R6 rdy v%0d", v), 64'(m_rdy_o), 64'(VEC[v].e_rdy));
      chk($sformatf("R4 R5 err v%0d", v), 64'(m_err_o), 64'(VEC[v].e_err));
    end

    // R3 R6 R7: CPU holds memory, DMA arrives late
    @(negedge clk_i);
    m_req_i = 3'b100; t_done_i = 3'b000;
    m_addr_i[2] = 32'h0000_0040; m_we_i[2] = 1'b1; m_wdata_i[2] = 32'hCAFE_0001;
    #2;
    chk("R7 mid", 64'(t_mid_o[0]), 64'd2);
    chk("R7 addr", 64'(t_addr_o[0]), 64'h0000_0040);
    chk("R7 we/wdata", 64'({t_we_o[0], t_wdata_o[0]}), {31'h0, 1'b1, 32'hCAFE_0001});
    chk("R6 rdy before done", 64'(m_rdy_o), 64'h0);
    @(negedge clk_i);
    m_req_i = 3'b101; m_addr_i[0] = 32'h0000_0080;
    #2;
    chk("R3 cpu keeps grant", 64'(t_mid_o[0]), 64'd2);
    chk("R6 dma waits", 64'(m_rdy_o), 64'h0);
    @(negedge clk_i); #2;
    chk("R3 cpu keeps grant 2", 64'(t_mid_o[0]), 64'd2);
    chk("R7 addr held", 64'(t_addr_o[0]), 64'h0000_0040);
    @(negedge clk_i);
    t_done_i = 3'b001; t_rdata_i[0] = 32'h1234_ABCD;
    #2;
    chk("R8 cpu rdy", 64'({m_rdy_o, m_err_o}), 64'({3'b100, 3'b000}));
    chk("R8 rdata", 64'(m_rdata_o[2]), 64'h1234_ABCD);
    @(negedge clk_i);
    m_req_i = 3'b001; m_we_i = '0; t_done_i = 3'b000;
    #2;
    chk("R2 dma next", 64'(t_mid_o[0]), 64'd0);
    chk("R6 dma no rdy yet", 64'(m_rdy_o), 64'h0);
    @(negedge clk_i);
    t_done_i = 3'b001; t_rdata_i[0] = 32'h0BAD_F00D;
    #2;
    chk("R8 dma rdy", 64'(m_rdy_o), 64'h1);
    chk("R8 dma rdata", 64'(m_rdata_o[0]), 64'h0BAD_F00D);

    // R5: memory window edges
    @(negedge clk_i);
    m_req_i = 3'b100; m_addr_i[2] = 32'h0004_0000;
    #2;
    chk("R5 past mem edge", 64'({t_req_o, m_rdy_o, m_err_o}), 64'({3'b000, 3'b100, 3'b100}));
    @(negedge clk_i);
    m_addr_i[2] = 32'h0003_FFFC;
    #2;
    chk("R5 last mem word", 64'({t_req_o, m_rdy_o, m_err_o}), 64'({3'b001, 3'b100, 3'b000}));
    @(negedge clk_i);
    m_req_i = '0; t_done_i = '0;
    @(negedge clk_i); #2;
    chk("R9 idle", 64'({t_req_o, m_rdy_o}), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule